// File: doc/BRIEF.md
# Audio Delay and Feedback Echo Stage

This block is one stage of an audio effects chain. It runs on a fast system clock and takes one signed 16-bit mono sample each time the sample-enable strobe is high. For each strobe it returns one processed sample. One synchronous dual-port memory, used as a circular buffer, holds the past samples. The delay length is given in sample periods.

It has two modes, chosen by a mode input. In plain delay mode the buffer stores the dry input. The output is the dry sample plus a scaled copy of the sample stored N periods earlier. In feedback echo mode the block stores the dry input plus an attenuated copy of the delayed sample. The echoes therefore repeat and decay on each pass. Echo mode has a shorter maximum delay. Buffer locations not yet written since reset read as silence, and a fill counter tracks which locations those are.

The buffer depth is 2^AW. With AW set to 16, the buffer holds just under 1.5 s of audio at 44.1 kHz. The default AW keeps the memory small.

Top module: `echo_delay`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` is set to 0 and `dout_vld` to 0, and all stored history is treated as never written.
- R2: For a strobe seen at rising edge E, `dout` and `dout_vld` update at the next edge after E. This is the second edge counting E. `dout_vld` is high for exactly one cycle, and `dout` holds its value between updates. Strobes must be at least 3 cycles apart.
- R3: In delay mode (`mode`=0) the stored value is the input sample x. The output is sat(x + floor(w*mix/256)), where w is the value stored N samples earlier.
- R4: If fewer than N samples have been stored since reset, w is 0, so the output equals the dry input.
- R5: Every sum saturates to the range -32768 to 32767.
- R6: In echo mode (`mode`=1) the stored value is sat(x + floor(w*fb_gain/256)), and the output formula is the same as in R3.
- R7: The delay length is N = `dly_len`, which can be up to 2^AW-1 (1023 by default) in delay mode. In echo mode N is limited to ECHO_MAX (255 by default).
- R8: `dly_len`, `mode`, `fb_gain` and `mix` are sampled at the strobe. A change takes effect at the next strobe.
- R9: Delays stay correct after the write pointer wraps past the end of the buffer.
- R10: `dly_len`=0 is treated as N=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe, one cycle per sample |
| mode | input | 1 | 0 = plain delay, 1 = feedback echo |
| dly_len | input | AW | Delay length N in samples |
| fb_gain | input | 8 | Feedback gain, unsigned Q0.8 |
| mix | input | 8 | Wet level, unsigned Q0.8 |
| din | input | 16 | Signed input sample |
| dout | output | 16 | Signed processed sample |
| dout_vld | output | 1 | One-cycle pulse when `dout` is updated |

## Verification
The assertions check the following on every cycle:
- the two-edge latency and the single-cycle valid pulse;
- that the output holds between updates;
- the reset output state;
- the strobe spacing rule;
- that output equals the dry input when the wet level is zero;
- that output equals the dry input while the buffer holds fewer than N samples.

Only the bench's scenarios can show the following, because they depend on long sample histories that a bench model tracks:
- exact wet values;
- saturation at both rails;
- decay of the recirculated echoes;
- the echo-length limit;
- changes of length in mid-stream;
- wrap-around of the write pointer.

// File: rtl/echo_delay.sv
module echo_delay #(
  parameter int AW       = 10,
  parameter int ECHO_MAX = 255
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_en,
  input  logic                mode,
  input  logic [AW-1:0]       dly_len,
  input  logic [7:0]          fb_gain,
  input  logic [7:0]          mix,
  input  logic signed [15:0]  din,
  output logic signed [15:0]  dout,
  output logic                dout_vld
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] EMAX = AW'(ECHO_MAX);

  function automatic logic signed [15:0] sat16(input logic signed [17:0] v);
    if (v > 18'sd32767)       return 16'sh7fff;
    else if (v < -18'sd32768) return 16'sh8000;
    else                      return v[15:0];
  endfunction

  function automatic logic signed [16:0] scale(input logic signed [15:0] s, input logic [7:0] g);
    logic signed [24:0] p;
    p = s * $signed({1'b0, g});
    return $signed(p[24:8]);
  endfunction

  logic signed [15:0] mem [DEPTH];
  logic signed [15:0] rdata, dry_q, wdata;
  logic [AW-1:0]      wptr, n_req, n_eff, raddr;
  logic [AW:0]        fill;
  logic               stg1, hit, mode_q;
  logic [7:0]         fb_q, mix_q;

  assign n_req = (dly_len == '0) ? AW'(1) : dly_len;
  assign n_eff = (mode && n_req > EMAX) ? EMAX : n_req;
  assign raddr = wptr - n_eff;

  always_ff @(posedge clk) begin
    if (smp_en) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (stg1) mem[wptr] <= wdata;
  end

  logic signed [15:0] wet;
  logic signed [16:0] fb_sc, mix_sc;
  logic signed [17:0] fb_sum, out_sum;

  assign wet     = hit ? rdata : 16'sd0;
  assign fb_sc   = scale(wet, fb_q);
  assign mix_sc  = scale(wet, mix_q);
  assign fb_sum  = 18'(dry_q) + 18'(fb_sc);
  assign out_sum = 18'(dry_q) + 18'(mix_sc);
  assign wdata   = mode_q ? sat16(fb_sum) : dry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1     <= 1'b0;
      wptr     <= '0;
      fill     <= '0;
      hit      <= 1'b0;
      dry_q    <= '0;
      mode_q   <= 1'b0;
      fb_q     <= '0;
      mix_q    <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      stg1     <= smp_en;
      dout_vld <= stg1;
      if (smp_en) begin
        dry_q  <= din;
        mode_q <= mode;
        fb_q   <= fb_gain;
        mix_q  <= mix;
        hit    <= ({1'b0, n_eff} <= fill);
      end
      if (stg1) begin
        dout <= sat16(out_sum);
        wptr <= wptr + AW'(1);
        if (fill != FULL) fill <= fill + (AW+1)'(1);
      end
    end
  end
endmodule

// File: rtl/echo_delay_chk.sv
module echo_delay_chk #(
  parameter int AW = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               smp_en,
  input logic               mode,
  input logic [AW-1:0]      dly_len,
  input logic [7:0]         mix,
  input logic signed [15:0] din,
  input logic signed [15:0] dout,
  input logic               dout_vld
);
  logic [AW:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (dout_vld && !seen[AW]) seen <= seen + (AW+1)'(1);
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    dout_vld == $past(smp_en, 2)) else $error("vld latency"); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_en, 2) |-> $stable(dout)) else $error("dout moved"); // R2
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    smp_en |-> (!$past(smp_en) && !$past(smp_en, 2))) else $error("strobe gap"); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (dout == 16'sd0 && !dout_vld)) else $error("reset state"); // R1
  AST_DRY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && $past(mix, 2) == 8'd0) |-> dout == $past(din, 2)) else $error("dry path"); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && !$past(mode, 2) && $past(dly_len, 2) != '0 && seen < {1'b0, $past(dly_len, 2)})
      |-> dout == $past(din, 2)) else $error("unwritten not zero"); // R4
endmodule

bind echo_delay echo_delay_chk u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .mode(mode), .dly_len(dly_len),
  .mix(mix), .din(din), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/echo_delay_tb.sv
module echo_delay_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic mode = 1'b0;
  logic [9:0] dly_len = 10'd1;
  logic [7:0] fb_gain = 8'd0;
  logic [7:0] mix = 8'd0;
  logic signed [15:0] din = 16'sd0;
  logic signed [15:0] dout;
  logic dout_vld;

  int checks = 0;
  int fails = 0;
  int hist[8192];
  int k = 0;

  always #10 clk = ~clk;

  echo_delay u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .mode(mode), .dly_len(dly_len),
    .fb_gain(fb_gain), .mix(mix), .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int fl(input int w, input int g);
    int p;
    p = w * g;
    return p >>> 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    k = 0;
  endtask

  task automatic step(input int x, input string req);
    int n, w, exp;
    n = (dly_len == 0) ? 1 : int'(dly_len);
    if (mode && n > 255) n = 255;
    w = (k >= n) ? hist[k-n] : 0;
    hist[k] = mode ? sat(x + fl(w, int'(fb_gain))) : x;
    k++;
    exp = sat(x + fl(w, int'(mix)));
    din = 16'(x);
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    @(negedge clk);
    check(dout_vld && int'(dout) == exp, req, int'(dout), exp);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check(dout == 16'sd0, "R1 dout", int'(dout), 0);
    check(dout_vld == 1'b0, "R1 vld", int'(dout_vld), 0);
  endtask

  task automatic t_timing();
    do_reset();
    mode = 0; dly_len = 10'd2; mix = 8'd128;
    din = 16'sd1234; smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    check(dout_vld == 1'b0, "R2 vld early", int'(dout_vld), 0);
    check(dout == 16'sd0, "R2 dout early", int'(dout), 0);
    @(negedge clk);
    check(dout_vld == 1'b1, "R2 vld on time", int'(dout_vld), 1);
    check(dout == 16'sd1234, "R2 dout on time", int'(dout), 1234);
    @(negedge clk);
    check(dout_vld == 1'b0, "R2 vld one cycle", int'(dout_vld), 0);
    check(dout == 16'sd1234, "R2 dout hold", int'(dout), 1234);
    hist[0] = 1234; k = 1;
  endtask

  task automatic t_delay();
    do_reset();
    mode = 0; dly_len = 10'd4; mix = 8'd128;
    for (int i = 0; i < 12; i++) step((i == 0) ? 8000 : i * 100 - 500, "R3 delay");
    mix = 8'd200;
    for (int i = 0; i < 6; i++) step(-3000 + i * 1111, "R3 delay mix");
  endtask

  task automatic t_empty();
    do_reset();
    mode = 0; dly_len = 10'd6; mix = 8'd255;
    for (int i = 0; i < 6; i++) step(500 + i, "R4 empty");
    step(0, "R4 first wet");
  endtask

  task automatic t_sat();
    do_reset();
    mode = 0; dly_len = 10'd1; mix = 8'd255;
    step(30000, "R5 sat");
    step(30000, "R5 sat high");
    check(dout == 16'sh7fff, "R5 high rail", int'(dout), 32767);
    step(-30000, "R5 sat");
    step(-30000, "R5 sat low");
    check(dout == 16'sh8000, "R5 low rail", int'(dout), -32768);
    do_reset();
    mode = 1; fb_gain = 8'd255;
    step(30000, "R5 echo store");
    step(30000, "R5 echo store");
    step(0, "R5 echo stored sat");
  endtask

  task automatic t_echo();
    do_reset();
    mode = 1; dly_len = 10'd3; fb_gain = 8'd128; mix = 8'd255;
    step(16000, "R6 echo impulse");
    for (int i = 0; i < 15; i++) step(0, "R6 echo decay");
    fb_gain = 8'd64;
    step(-12000, "R6 echo neg");
    for (int i = 0; i < 9; i++) step(0, "R6 echo decay");
  endtask

  task automatic t_clamp();
    do_reset();
    mode = 1; dly_len = 10'd300; fb_gain = 8'd200; mix = 8'd255;
    step(20000, "R7 clamp");
    for (int i = 0; i < 260; i++) step(0, "R7 clamp");
    do_reset();
    mode = 0; dly_len = 10'd1023; mix = 8'd128;
    for (int i = 0; i < 1023; i++) step((i == 0) ? 9000 : 0, "R7 max len");
    step(0, "R7 max len wet");
  endtask

  task automatic t_change();
    do_reset();
    mode = 0; dly_len = 10'd2; mix = 8'd128; fb_gain = 8'd100;
    for (int i = 0; i < 5; i++) step(1000 * (i + 1), "R8 len2");
    dly_len = 10'd4;
    for (int i = 0; i < 5; i++) step(-700 * i, "R8 len4");
    mode = 1;
    for (int i = 0; i < 5; i++) step(300 * i, "R8 mode switch");
    mix = 8'd0; dly_len = 10'd1;
    for (int i = 0; i < 3; i++) step(42 + i, "R8 mix change");
  endtask

  task automatic t_wrap();
    do_reset();
    mode = 0; dly_len = 10'd1000; mix = 8'd192;
    for (int i = 0; i < 1100; i++) step((i * 37) % 20000 - 10000, "R9 wrap");
  endtask

  task automatic t_zero_len();
    do_reset();
    mode = 0; dly_len = 10'd0; mix = 8'd128;
    for (int i = 0; i < 5; i++) step(2000 + 500 * i, "R10 zero len");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_timing();
    t_delay();
    t_empty();
    t_sat();
    t_echo();
    t_clamp();
    t_change();
    t_wrap();
    t_zero_len();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule